// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Unit

This block resolves read-after-write hazards for an in-order pipeline with five stages: fetch, register read, ALU, memory and write-back. Results reach the register file three stages after the register-read stage. Up to three older instructions may therefore still hold a newer value for a register that the instruction in register read is reading. For each of its two source operands the unit compares the register number against the destination of the instructions in the ALU, memory and write-back stages. It then delivers the value from the youngest matching stage, or the register-file read data when no stage matches.

Load data only exists once the load has reached write-back. A consumer that depends on a load still in the ALU or memory stage cannot take its value from a bypass path. The unit then freezes fetch and register read and asks for a no-op to be placed in the ALU stage. It keeps doing so until the load sits in write-back, and the waiting instruction then takes the load data from the write-back bypass path. A two-state sequencer drives the interlock. In RUN it stalls when it sees a load match in the ALU stage, and then moves to HOLD. In RUN it also stalls on a load match in the memory stage, and in that case it stays in RUN. HOLD stalls unconditionally and always returns to RUN. HOLD depends on the surrounding pipeline obeying the freeze: while in HOLD the load sits in the memory stage and the consumer waits in register read.

The matching destination register can be the Rd field, the Rt field or register 31 (jump-and-link). That choice is decoded before this block, which receives the final destination number for each stage.

Top module: `opb_hazard_unit`

## Requirements
- R1: A source register is matched by a stage only when that stage's write-enable is 1, its destination equals the source number and the source number is not 0. When no stage matches, the operand equals the register-file read data.
- R2: A source matched by the ALU stage holding a non-load instruction takes the ALU-stage result in the same cycle.
- R3: A source matched by the memory stage, with no ALU-stage match, takes the memory-stage result.
- R4: A source matched only by the write-back stage takes the write-back result, which for a load is the load data.
- R5: When several stages match, priority goes to the youngest: ALU first, then memory, then write-back.
- R6: Source register 0 always yields the value 0, whatever the register-file data and whatever any stage writes to register 0. Register 0 never causes a stall.
- R7: A stage whose write-enable is 0 never supplies an operand, whatever its destination number.
- R8: A source that matches a load in the ALU stage asserts the stall in that cycle and in the following cycle: two bubbles. The sequencer moves RUN to HOLD, then HOLD to RUN.
- R9: A source that matches a load in the memory stage (with the sequencer in RUN) stalls for exactly one cycle.
- R10: While stalled, fetch_en and decode_en are 0 and bubble is 1. Otherwise fetch_en and decode_en are 1 and bubble is 0.
- R11: The two operands are resolved independently. One may be forwarded while the other waits on a load, and on release both carry the sequentially correct values.
- R12: Reset puts the sequencer in RUN, even when it is taken while in HOLD. With an idle pipeline this gives no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rs1_idx | input | RAW | Source register number, operand A |
| rs2_idx | input | RAW | Source register number, operand B |
| rf_rs1_data | input | XLEN | Register-file read data for operand A |
| rf_rs2_data | input | XLEN | Register-file read data for operand B |
| ex_wen | input | 1 | ALU-stage instruction writes a register |
| ex_load | input | 1 | ALU-stage instruction is a load |
| ex_dst | input | RAW | ALU-stage destination register |
| ex_result | input | XLEN | ALU-stage result |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_dst | input | RAW | Memory-stage destination register |
| mem_result | input | XLEN | Memory-stage result (address for a load) |
| wb_wen | input | 1 | Write-back instruction writes a register |
| wb_dst | input | RAW | Write-back destination register |
| wb_result | input | XLEN | Write-back value (load data for a load) |
| opa | output | XLEN | Resolved operand A |
| opb | output | XLEN | Resolved operand B |
| fetch_en | output | 1 | Fetch-stage clock enable |
| decode_en | output | 1 | Register-read-stage clock enable |
| bubble | output | 1 | Place a no-op in the ALU stage at the next edge |

## Verification
Bypass selection and the load interlock can act in the same cycle on different operands. One operand is taken from a non-load stage while the other waits on a load in the memory stage. The bench provokes this by issuing a load, then an ALU instruction, then a consumer that reads both results. It expects exactly one bubble, followed by both operands matching a sequential register model. A second case has two back-to-back loads, where the address of the second load depends on the first. This puts the HOLD path directly behind a released stall.

// File: rtl/opb_pkg.sv
package opb_pkg;
    // Stage slots seen by the bypass network, youngest first
    localparam int NSTG    = 3;
    localparam int STG_EX  = 0;
    localparam int STG_MEM = 1;
    localparam int STG_WB  = 2;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } ilk_state_e;
endpackage

// File: rtl/opb_src_match.sv
module opb_src_match
    import opb_pkg::*;
#(
    parameter int RAW = 5
) (
    input  logic [RAW-1:0]            src,
    input  logic [NSTG-1:0][RAW-1:0]  dst,
    input  logic [NSTG-1:0]           wen,
    input  logic [1:0]                ld_early,
    output logic [NSTG-1:0]           hit,
    output logic                      hz_ex,
    output logic                      hz_mem
);
    logic src_live;
    assign src_live = |src;

    for (genvar g = 0; g < NSTG; g++) begin : g_stg
        assign hit[g] = src_live && wen[g] && (dst[g] == src);
    end

    // Load data is not ready before write-back
    assign hz_ex  = hit[STG_EX]  && ld_early[0];
    assign hz_mem = hit[STG_MEM] && ld_early[1];
endmodule

// File: rtl/opb_operand_sel.sv
module opb_operand_sel
    import opb_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                      src_zero,
    input  logic [NSTG-1:0]           hit,
    input  logic [NSTG-1:0][XLEN-1:0] cand,
    input  logic [XLEN-1:0]           rf_data,
    output logic [XLEN-1:0]           value
);
    always_comb begin
        value = src_zero ? '0 : rf_data;
        // Walk oldest to youngest so the youngest match wins
        for (int s = NSTG - 1; s >= 0; s--) begin
            if (hit[s]) value = cand[s];
        end
    end
endmodule

// File: rtl/opb_interlock_fsm.sv
module opb_interlock_fsm
    import opb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hz_ex,
    input  logic hz_mem,
    output logic stall
);
    ilk_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:  if (hz_ex) st_d = ST_HOLD;
            ST_HOLD: st_d = ST_RUN;
        endcase
    end

    always_comb begin
        stall = 1'b0;
        unique case (st_q)
            ST_RUN:  stall = hz_ex || hz_mem;
            ST_HOLD: stall = 1'b1;
        endcase
    end
endmodule

// File: rtl/opb_hazard_unit.sv
module opb_hazard_unit
    import opb_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int RAW  = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RAW-1:0]  rs1_idx,
    input  logic [RAW-1:0]  rs2_idx,
    input  logic [XLEN-1:0] rf_rs1_data,
    input  logic [XLEN-1:0] rf_rs2_data,
    input  logic            ex_wen,
    input  logic            ex_load,
    input  logic [RAW-1:0]  ex_dst,
    input  logic [XLEN-1:0] ex_result,
    input  logic            mem_wen,
    input  logic            mem_load,
    input  logic [RAW-1:0]  mem_dst,
    input  logic [XLEN-1:0] mem_result,
    input  logic            wb_wen,
    input  logic [RAW-1:0]  wb_dst,
    input  logic [XLEN-1:0] wb_result,
    output logic [XLEN-1:0] opa,
    output logic [XLEN-1:0] opb,
    output logic            fetch_en,
    output logic            decode_en,
    output logic            bubble
);
    localparam int NOPND = 2;

    logic [NOPND-1:0][RAW-1:0]  src_idx;
    logic [NOPND-1:0][XLEN-1:0] rf_val;
    logic [NOPND-1:0][XLEN-1:0] opnd;
    logic [NSTG-1:0][RAW-1:0]   stg_dst;
    logic [NSTG-1:0]            stg_wen;
    logic [NSTG-1:0][XLEN-1:0]  stg_val;
    logic [1:0]                 early_ld;
    logic [NOPND-1:0]           hz_ex_v;
    logic [NOPND-1:0]           hz_mem_v;
    logic                       stall;

    assign src_idx[0] = rs1_idx;
    assign src_idx[1] = rs2_idx;
    assign rf_val[0]  = rf_rs1_data;
    assign rf_val[1]  = rf_rs2_data;

    assign stg_dst[STG_EX]  = ex_dst;
    assign stg_dst[STG_MEM] = mem_dst;
    assign stg_dst[STG_WB]  = wb_dst;
    assign stg_wen[STG_EX]  = ex_wen;
    assign stg_wen[STG_MEM] = mem_wen;
    assign stg_wen[STG_WB]  = wb_wen;
    assign stg_val[STG_EX]  = ex_result;
    assign stg_val[STG_MEM] = mem_result;
    assign stg_val[STG_WB]  = wb_result;
    assign early_ld         = {mem_load, ex_load};

    for (genvar o = 0; o < NOPND; o++) begin : g_opnd
        logic [NSTG-1:0] hit;

        opb_src_match #(.RAW(RAW)) u_match (
            .src      (src_idx[o]),
            .dst      (stg_dst),
            .wen      (stg_wen),
            .ld_early (early_ld),
            .hit      (hit),
            .hz_ex    (hz_ex_v[o]),
            .hz_mem   (hz_mem_v[o])
        );

        opb_operand_sel #(.XLEN(XLEN)) u_sel (
            .src_zero (src_idx[o] == '0),
            .hit      (hit),
            .cand     (stg_val),
            .rf_data  (rf_val[o]),
            .value    (opnd[o])
        );
    end

    opb_interlock_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .hz_ex  (|hz_ex_v),
        .hz_mem (|hz_mem_v),
        .stall  (stall)
    );

    assign opa       = opnd[0];
    assign opb       = opnd[1];
    assign fetch_en  = ~stall;
    assign decode_en = ~stall;
    assign bubble    = stall;
endmodule

// File: rtl/opb_hazard_checker.sv
module opb_hazard_checker #(
    parameter int XLEN = 32,
    parameter int RAW  = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [RAW-1:0]  rs1_idx,
    input logic [RAW-1:0]  rs2_idx,
    input logic [XLEN-1:0] rf_rs1_data,
    input logic [XLEN-1:0] rf_rs2_data,
    input logic            ex_wen,
    input logic            ex_load,
    input logic [RAW-1:0]  ex_dst,
    input logic [XLEN-1:0] ex_result,
    input logic            mem_wen,
    input logic            mem_load,
    input logic [RAW-1:0]  mem_dst,
    input logic [XLEN-1:0] mem_result,
    input logic            wb_wen,
    input logic [RAW-1:0]  wb_dst,
    input logic [XLEN-1:0] wb_result,
    input logic [XLEN-1:0] opa,
    input logic [XLEN-1:0] opb,
    input logic            fetch_en,
    input logic            decode_en,
    input logic            bubble
);
    logic a_ex, a_mem, a_wb, b_ex, b_mem, b_wb;
    assign a_ex  = (rs1_idx != '0) && ex_wen  && (ex_dst  == rs1_idx);
    assign a_mem = (rs1_idx != '0) && mem_wen && (mem_dst == rs1_idx);
    assign a_wb  = (rs1_idx != '0) && wb_wen  && (wb_dst  == rs1_idx);
    assign b_ex  = (rs2_idx != '0) && ex_wen  && (ex_dst  == rs2_idx);
    assign b_mem = (rs2_idx != '0) && mem_wen && (mem_dst == rs2_idx);
    assign b_wb  = (rs2_idx != '0) && wb_wen  && (wb_dst  == rs2_idx);

    AST_RF_PASS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (rs1_idx != '0 && !a_ex && !a_mem && !a_wb) |-> opa == rf_rs1_data); // R1
    AST_IDLE_STAGES_B: assert property (@(posedge clk) disable iff (!rst_n)
        (rs2_idx != '0 && !ex_wen && !mem_wen && !wb_wen) |-> opb == rf_rs2_data); // R7
    AST_EX_FWD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ex && !ex_load) |-> opa == ex_result); // R2
    AST_MEM_FWD_B: assert property (@(posedge clk) disable iff (!rst_n)
        (b_mem && !b_ex && !mem_load) |-> opb == mem_result); // R3
    AST_WB_FWD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wb && !a_ex && !a_mem) |-> opa == wb_result); // R4
    AST_ZERO_SRC_A: assert property (@(posedge clk) disable iff (!rst_n)
        (rs1_idx == '0) |-> opa == '0); // R6
    AST_ZERO_SRC_B: assert property (@(posedge clk) disable iff (!rst_n)
        (rs2_idx == '0) |-> opb == '0); // R6
    AST_EX_LOAD_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_ex || b_ex) && ex_load) |-> bubble); // R8
    AST_EX_LOAD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_ex || b_ex) && ex_load) |=> bubble); // R8
    AST_MEM_LOAD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_mem || b_mem) && mem_load && !a_ex && !b_ex) |-> bubble); // R9
    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |-> (!fetch_en && !decode_en)); // R10
    AST_RUN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !bubble |-> (fetch_en && decode_en)); // R10
endmodule

bind opb_hazard_unit opb_hazard_checker #(.XLEN(XLEN), .RAW(RAW)) u_chk (.*);

// File: tb/opb_hazard_unit_test.sv
module opb_hazard_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int K_NOP = 0, K_ALU = 1, K_LD = 2, K_NW = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rs1_idx, rs2_idx, ex_dst, mem_dst, wb_dst;
    logic [31:0] rf_rs1_data, rf_rs2_data, ex_result, mem_result, wb_result;
    logic        ex_wen, ex_load, mem_wen, mem_load, wb_wen;
    logic [31:0] opa, opb;
    logic        fetch_en, decode_en, bubble;

    opb_hazard_unit uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;

    // program store
    int          n_ins, pc;
    int          pk [64];
    logic [4:0]  pd [64], ps1 [64], ps2 [64];
    logic [31:0] pim [64];

    // bench pipeline model
    int          id_k, ex_k, mem_k, wb_k;
    logic [4:0]  id_d, id_s1, id_s2, ex_d, mem_d, wb_d;
    logic [31:0] id_im, ex_a, ex_b, ex_im, mem_v, wb_v;
    logic [31:0] regfile_m [32];
    logic [31:0] arch_m [32];

    function automatic logic [31:0] ld_data(input logic [31:0] addr);
        return (addr * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    function automatic logic [31:0] stage_res(input int k, input logic [31:0] a, b, im);
        return (k == K_LD) ? a + im : a + b + im;
    endfunction

    function automatic logic [31:0] arch_rd(input logic [4:0] s);
        return (s == 5'd0) ? 32'h0 : arch_m[s];
    endfunction

    function automatic logic writes(input int k);
        return (k == K_ALU) || (k == K_LD);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic add(input int k, input logic [4:0] d, s1, s2, input logic [31:0] im);
        pk[n_ins] = k; pd[n_ins] = d; ps1[n_ins] = s1; ps2[n_ins] = s2; pim[n_ins] = im;
        n_ins++;
    endtask

    task automatic drive();
        rs1_idx     = id_s1;
        rs2_idx     = id_s2;
        rf_rs1_data = regfile_m[id_s1];
        rf_rs2_data = regfile_m[id_s2];
        ex_wen      = writes(ex_k);
        ex_load     = (ex_k == K_LD);
        ex_dst      = ex_d;
        ex_result   = stage_res(ex_k, ex_a, ex_b, ex_im);
        mem_wen     = writes(mem_k);
        mem_load    = (mem_k == K_LD);
        mem_dst     = mem_d;
        mem_result  = mem_v;
        wb_wen      = writes(wb_k);
        wb_dst      = wb_d;
        wb_result   = wb_v;
    endtask

    // one clock: drive after posedge, judge at negedge, advance model
    task automatic cyc(input string tag, inout int stalls);
        logic [31:0] ea, eb;
        logic st;
        drive();
        @(negedge clk);
        st = bubble;
        chk(fetch_en == !st && decode_en == !st, "R10 enables vs bubble",
            {30'b0, fetch_en, decode_en}, {30'b0, !st, !st});
        ea = arch_rd(id_s1);
        eb = arch_rd(id_s2);
        if (!st && id_k != K_NOP) begin
            chk(opa == ea, {tag, " operand A"}, opa, ea);
            chk(opb == eb, {tag, " operand B"}, opb, eb);
            if (writes(id_k) && id_d != 5'd0)
                arch_m[id_d] = (id_k == K_LD) ? ld_data(ea + id_im) : ea + eb + id_im;
        end
        if (st) stalls++;
        if (writes(wb_k) && wb_d != 5'd0) regfile_m[wb_d] = wb_v;
        wb_k = mem_k; wb_d = mem_d;
        wb_v = (mem_k == K_LD) ? ld_data(mem_v) : mem_v;
        mem_k = ex_k; mem_d = ex_d; mem_v = stage_res(ex_k, ex_a, ex_b, ex_im);
        if (st) begin
            ex_k = K_NOP; ex_d = 5'd0; ex_a = 0; ex_b = 0; ex_im = 0;
        end else begin
            ex_k = id_k; ex_d = id_d; ex_a = ea; ex_b = eb; ex_im = id_im;
            if (pc < n_ins) begin
                id_k = pk[pc]; id_d = pd[pc]; id_s1 = ps1[pc]; id_s2 = ps2[pc]; id_im = pim[pc];
                pc++;
            end else begin
                id_k = K_NOP; id_d = 0; id_s1 = 0; id_s2 = 0; id_im = 0;
            end
        end
        @(posedge clk);
        #1;
    endtask

    task automatic run_prog(input string tag, input int exp_stalls);
        int stalls = 0;
        pc = 0;
        while (pc < n_ins) cyc(tag, stalls);
        for (int i = 0; i < 7; i++) cyc(tag, stalls);
        chk(stalls == exp_stalls, {tag, " bubble count"}, stalls, exp_stalls);
        n_ins = 0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk(bubble == 1'b0 && fetch_en && decode_en, "R12 idle after reset",
            {31'b0, bubble}, 32'h0);
        chk(opa == regfile_m[7], "R1 register-file pass-through", opa, regfile_m[7]);
    endtask

    task automatic t_reset_from_hold();
        // provoke HOLD, then reset must bring back RUN
        rs1_idx = 5'd9; ex_wen = 1; ex_load = 1; ex_dst = 5'd9;
        @(negedge clk);
        chk(bubble == 1'b1, "R8 load in ALU stage stalls", {31'b0, bubble}, 32'h1);
        @(posedge clk); #1;
        rst_n = 1'b0;
        ex_wen = 0; ex_load = 0; ex_dst = 0; rs1_idx = 0;
        @(negedge clk);
        chk(bubble == 1'b0, "R12 reset leaves HOLD", {31'b0, bubble}, 32'h0);
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    task automatic t_alu_chain();
        add(K_ALU, 1, 2, 3, 5);
        add(K_ALU, 2, 1, 1, 1);
        add(K_ALU, 3, 2, 1, 0);
        add(K_ALU, 4, 3, 2, 0);
        add(K_ALU, 5, 4, 1, 0);
        run_prog("R2 R3 R4 back-to-back ALU chain", 0);
    endtask

    task automatic t_priority();
        add(K_ALU, 7, 1, 1, 1);
        add(K_ALU, 7, 2, 2, 2);
        add(K_ALU, 7, 3, 3, 3);
        add(K_ALU, 8, 7, 7, 0);
        add(K_ALU, 9, 1, 2, 4);
        add(K_ALU, 9, 3, 4, 5);
        add(K_ALU, 10, 1, 1, 0);
        add(K_ALU, 11, 9, 9, 0);
        run_prog("R5 youngest-stage priority", 0);
    endtask

    task automatic t_load_use();
        add(K_LD, 6, 1, 0, 4);
        add(K_ALU, 12, 6, 2, 0);
        run_prog("R8 load then immediate use", 2);
        add(K_LD, 26, 2, 0, 8);
        add(K_ALU, 27, 3, 26, 0);
        run_prog("R8 load then use on operand B", 2);
    endtask

    task automatic t_load_gap();
        add(K_LD, 13, 3, 0, 12);
        add(K_ALU, 14, 1, 1, 0);
        add(K_ALU, 15, 13, 13, 0);
        run_prog("R9 load one instruction ahead", 1);
        add(K_LD, 16, 4, 0, 2);
        add(K_ALU, 14, 1, 2, 0);
        add(K_ALU, 15, 2, 3, 0);
        add(K_ALU, 17, 2, 16, 0);
        run_prog("R4 load data via write-back", 0);
    endtask

    task automatic t_zero_reg();
        add(K_ALU, 0, 1, 2, 3);
        add(K_ALU, 18, 0, 0, 1);
        add(K_LD, 0, 2, 0, 0);
        add(K_ALU, 19, 0, 3, 0);
        run_prog("R6 register zero", 0);
    endtask

    task automatic t_wen_clear();
        add(K_ALU, 20, 1, 1, 9);
        add(K_NW, 20, 2, 2, 0);
        add(K_ALU, 21, 20, 20, 0);
        add(K_NW, 22, 3, 3, 0);
        add(K_ALU, 23, 22, 22, 0);
        run_prog("R7 write-enable clear", 0);
    endtask

    task automatic t_mixed();
        add(K_LD, 23, 1, 0, 6);
        add(K_ALU, 24, 1, 1, 0);
        add(K_ALU, 25, 24, 23, 0);
        run_prog("R11 forward and interlock together", 1);
        add(K_LD, 28, 5, 0, 0);
        add(K_LD, 29, 28, 0, 4);
        add(K_ALU, 30, 29, 28, 0);
        run_prog("R11 R8 back-to-back dependent loads", 4);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            regfile_m[i] = 32'h01010101 * i + 32'd7;
            arch_m[i]    = regfile_m[i];
        end
        regfile_m[0] = 32'hDEADBEEF;
        arch_m[0]    = 32'h0;
        n_ins = 0; pc = 0;
        id_k = K_NOP; id_d = 0; id_s1 = 0; id_s2 = 0; id_im = 0;
        ex_k = K_NOP; ex_d = 0; ex_a = 0; ex_b = 0; ex_im = 0;
        mem_k = K_NOP; mem_d = 0; mem_v = 0;
        wb_k = K_NOP; wb_d = 0; wb_v = 0;
        rst_n = 1'b0;
        drive();
        rs1_idx = 5'd7; rf_rs1_data = regfile_m[7];
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset_state();
        @(posedge clk); #1;
        t_reset_from_hold();
        t_alu_chain();
        t_priority();
        t_load_use();
        t_load_gap();
        t_zero_reg();
        t_wen_clear();
        t_mixed();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule